// File: doc/BRIEF.md
# SPI Slave with Select-Gated Shifter

This block is the receiving end of an SPI link. It takes the serial clock from an external master and clocks data in and out only while the active-low select line is low. When the select line is high, the block ignores the serial clock and keeps its shift logic still. It also releases the data output and drops any frame that was only partly received. When the select line goes low, the first bit of the transmit word appears on the output before the master sends any clock edge.

The serial clock, the select line and both data inputs pass through two-flop synchronizers into the system clock. Clock edges are detected on the synchronized serial clock. The bench therefore runs the serial clock several system cycles per half period.

The pins work in one of two ways. In full-duplex mode there is one input pin and one output pin. In single-wire mode one pin carries data both ways, and an output-enable control decides whether the block drives that pin. Clock polarity, clock phase, bit order and a frame width of 8 or 16 bits are all static inputs. A completed frame is copied to the receive register and marked by a one-cycle done pulse.

Top module: `spi_sel_slave`

## Requirements
- R1: While ss_ni is high (deselected), miso_oe_o and sio_oe_o are both 0.
- R2: Within four clk_i cycles after ss_ni falls, and before any SCK edge, the active output carries the first transmit bit. This is tx_data_i bit 0 when lsb_first_i=1, bit 15 when wide_i=1, and bit 7 otherwise.
- R3: SCK edges while ss_ni is high shift nothing, so the next selected frame is received and transmitted intact.
- R4: If ss_ni rises before a frame is complete, done_o does not pulse, rx_data_o keeps its previous value and the next frame starts from bit 0.
- R5: SCK idles at the level of cpol_i. With cpha_i=0 the input is sampled on the edge leaving idle and the output changes on the edge returning to idle. With cpha_i=1 the output changes on the edge leaving idle, except the first edge of a frame, and the input is sampled on the edge returning to idle.
- R6: With lsb_first_i=1 bit 0 is sent and received first. With lsb_first_i=0 the most significant bit of the frame comes first.
- R7: With wide_i=1 a frame has 16 bits. With wide_i=0 it has 8 bits, placed in rx_data_o[7:0], and rx_data_o[15:8] is zero.
- R8: After the last bit is sampled, rx_data_o takes the received word and done_o is high for exactly one clk_i cycle. rx_data_o changes in no other cycle.
- R9: With bidir_i=0 the block samples mosi_i and drives miso_o with miso_oe_o high while selected; sio_oe_o stays 0.
- R10: With bidir_i=1 the block samples sio_i and drives sio_o. sio_oe_o equals bidir_oe_i while selected, and miso_oe_o stays 0.
- R11: While ss_ni stays low, consecutive frames follow one another with no gap. tx_data_i is reloaded when each frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | Idle level of SCK |
| cpha_i | input | 1 | Clock phase select |
| lsb_first_i | input | 1 | Bit order: 1 sends bit 0 first |
| wide_i | input | 1 | Frame width: 1 selects 16 bits, 0 selects 8 |
| bidir_i | input | 1 | Single-wire pin mode |
| bidir_oe_i | input | 1 | Drive the shared pin in single-wire mode |
| sck_i | input | 1 | Serial clock from the master |
| ss_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data in (full-duplex mode) |
| miso_o | output | 1 | Serial data out (full-duplex mode) |
| miso_oe_o | output | 1 | Output enable for miso_o |
| sio_i | input | 1 | Shared pin, input side |
| sio_o | output | 1 | Shared pin, output side |
| sio_oe_o | output | 1 | Output enable for the shared pin |
| tx_data_i | input | 16 | Word to transmit |
| rx_data_o | output | 16 | Last complete received word |
| done_o | output | 1 | One-cycle pulse when a frame completes |

## Verification
The assertions check on every cycle that both output enables stay off while the synchronized select is high and are never on together. They also check that done_o never fires while deselected, that it lasts a single cycle, and that rx_data_o moves only with done_o. The bench scenarios cover what only whole transfers can show: bit order and width, sampling phase in all four clock modes, the first bit presented on select, frames lost to early deselect, clocks ignored while deselected, back-to-back frames and single-wire loopback.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  // bit positions inside the synchronized pin vector
  localparam int unsigned PIN_SCK  = 0;
  localparam int unsigned PIN_SS   = 1;
  localparam int unsigned PIN_MOSI = 2;
  localparam int unsigned PIN_SIO  = 3;
  localparam int unsigned PIN_CNT  = 4;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];

  initial begin
    a_sync_depth: assert (STAGES >= 2) else $error("sync needs two stages");
  end
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  input  logic cpol_i,
  output logic lead_o,
  output logic trail_o
);
  logic sck_q;
  logic moved;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s_i;
  end

  assign moved   = sck_s_i ^ sck_q;
  // leading edge leaves the idle level, trailing edge returns to it
  assign lead_o  = moved & (sck_s_i ^ cpol_i);
  assign trail_o = moved & ~(sck_s_i ^ cpol_i);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned MAX_W = 16,
  parameter int unsigned MIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             cpha_i,
  input  logic             lsb_first_i,
  input  logic             wide_i,
  input  logic             lead_i,
  input  logic             trail_i,
  input  logic             din_i,
  input  logic [MAX_W-1:0] tx_data_i,
  output logic             dout_o,
  output logic [MAX_W-1:0] rx_data_o,
  output logic             done_o
);
  localparam int unsigned CW  = $clog2(MAX_W + 1);
  localparam int unsigned PAD = MAX_W - MIN_W;

  logic [MAX_W-1:0] tx_sh_q, rx_sh_q, rx_nxt, tx_adv, word;
  logic [CW-1:0]    cnt_q, width_w;
  logic             skip_q, sample_edge, shift_edge, last;

  assign width_w     = wide_i ? CW'(MAX_W) : CW'(MIN_W);
  assign sample_edge = cpha_i ? trail_i : lead_i;
  assign shift_edge  = cpha_i ? lead_i  : trail_i;
  assign last        = sample_edge && (cnt_q == width_w - CW'(1));

  assign rx_nxt = lsb_first_i ? {din_i, rx_sh_q[MAX_W-1:1]}
                              : {rx_sh_q[MAX_W-2:0], din_i};
  assign tx_adv = lsb_first_i ? (tx_sh_q >> 1) : (tx_sh_q << 1);

  always_comb begin
    if (wide_i)           word = rx_nxt;
    else if (lsb_first_i) word = {{PAD{1'b0}}, rx_nxt[MAX_W-1 -: MIN_W]};
    else                  word = {{PAD{1'b0}}, rx_nxt[MIN_W-1:0]};
  end

  assign dout_o = lsb_first_i ? tx_sh_q[0]
                : (wide_i ? tx_sh_q[MAX_W-1] : tx_sh_q[MIN_W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      rx_data_o <= '0;
      cnt_q     <= '0;
      skip_q    <= 1'b0;
      done_o    <= 1'b0;
    end else if (!sel_i) begin
      // idle: hold the next word ready so the first bit is out on select
      tx_sh_q <= tx_data_i;
      cnt_q   <= '0;
      skip_q  <= cpha_i;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (sample_edge) begin
        rx_sh_q <= rx_nxt;
        if (last) begin
          cnt_q     <= '0;
          rx_data_o <= word;
          done_o    <= 1'b1;
          tx_sh_q   <= tx_data_i;
          skip_q    <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
      if (shift_edge) begin
        if (skip_q) skip_q  <= 1'b0;
        else        tx_sh_q <= tx_adv;
      end
    end
  end

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r4_no_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> !done_o);
  a_r8_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> done_o);
  a_r7_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(MAX_W));
  a_r3_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> cnt_q == '0);
endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave
  import spi_sel_pkg::*;
#(
  parameter int unsigned MAX_W = 16,
  parameter int unsigned MIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             lsb_first_i,
  input  logic             wide_i,
  input  logic             bidir_i,
  input  logic             bidir_oe_i,
  input  logic             sck_i,
  input  logic             ss_ni,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  input  logic             sio_i,
  output logic             sio_o,
  output logic             sio_oe_o,
  input  logic [MAX_W-1:0] tx_data_i,
  output logic [MAX_W-1:0] rx_data_o,
  output logic             done_o
);
  localparam logic [PIN_CNT-1:0] PIN_RST = PIN_CNT'(1) << PIN_SS;

  logic [PIN_CNT-1:0] pins_raw, pins_s;
  logic sel, din, dout, lead, trail;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_SCK]  = sck_i;
    pins_raw[PIN_SS]   = ss_ni;
    pins_raw[PIN_MOSI] = mosi_i;
    pins_raw[PIN_SIO]  = sio_i;
  end

  spi_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  spi_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_s_i(pins_s[PIN_SCK]),
    .cpol_i (cpol_i),
    .lead_o (lead),
    .trail_o(trail)
  );

  assign sel = ~pins_s[PIN_SS];
  assign din = bidir_i ? pins_s[PIN_SIO] : pins_s[PIN_MOSI];

  spi_shifter #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .cpha_i     (cpha_i),
    .lsb_first_i(lsb_first_i),
    .wide_i     (wide_i),
    .lead_i     (lead),
    .trail_i    (trail),
    .din_i      (din),
    .tx_data_i  (tx_data_i),
    .dout_o     (dout),
    .rx_data_o  (rx_data_o),
    .done_o     (done_o)
  );

  assign miso_o    = dout;
  assign sio_o     = dout;
  assign miso_oe_o = sel & ~bidir_i;
  assign sio_oe_o  = sel & bidir_i & bidir_oe_i;

  a_r1_release_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_s[PIN_SS] |-> (!miso_oe_o && !sio_oe_o));
  a_r10_one_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({miso_oe_o, sio_oe_o}) <= 1);
endmodule

// File: tb/spi_sel_slave_tb.sv
module spi_sel_slave_tb;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cpol = 0, cpha = 0, lsb = 0, wide = 0, bidir = 0, bidir_oe = 0;
  logic sck = 0, ss_n = 1, mosi = 0, m_sio = 0;
  logic sio_i;
  logic miso, miso_oe, sio_o, sio_oe, done;
  logic [15:0] tx_data = '0, rx_data;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  assign sio_i = sio_oe ? sio_o : m_sio;

  spi_sel_slave u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cpol_i(cpol), .cpha_i(cpha),
    .lsb_first_i(lsb), .wide_i(wide), .bidir_i(bidir), .bidir_oe_i(bidir_oe),
    .sck_i(sck), .ss_ni(ss_n), .mosi_i(mosi), .miso_o(miso), .miso_oe_o(miso_oe),
    .sio_i(sio_i), .sio_o(sio_o), .sio_oe_o(sio_oe),
    .tx_data_i(tx_data), .rx_data_o(rx_data), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fit(input logic [15:0] w);
    return wide ? w : {8'h00, w[7:0]};
  endfunction

  function automatic logic first_bit(input logic [15:0] w);
    return lsb ? w[0] : (wide ? w[15] : w[7]);
  endfunction

  function automatic logic slave_out();
    return bidir ? sio_o : miso;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_on();
    ss_n = 1'b0;
    wait_clk(4);
  endtask

  task automatic sel_off();
    ss_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic put_bit(input logic b);
    if (bidir) m_sio = b; else mosi = b;
  endtask

  // master side of one frame; stop_at < nb drops select-less abort (no push)
  task automatic frame(input logic [15:0] m_word, input logic [15:0] s_word,
                       input logic [15:0] nxt, input int stop_at, input string req);
    int nb = wide ? 16 : 8;
    logic [15:0] got = '0;
    logic [15:0] rx_exp;
    rx_exp = (bidir && bidir_oe) ? fit(s_word) : fit(m_word);
    if (stop_at >= nb) exp_q.push_back(rx_exp);
    for (int k = 0; k < nb && k < stop_at; k++) begin
      int idx = lsb ? k : nb - 1 - k;
      if (!cpha) begin
        put_bit(m_word[idx]);
        wait_clk(HALF);
        got[idx] = slave_out();
        sck = ~cpol;
        wait_clk(HALF);
        sck = cpol;
      end else begin
        sck = ~cpol;
        put_bit(m_word[idx]);
        wait_clk(HALF);
        got[idx] = slave_out();
        sck = cpol;
        wait_clk(HALF);
      end
      if (k == 0) tx_data = nxt;
    end
    wait_clk(HALF);
    if (stop_at >= nb && !(bidir && !bidir_oe))
      chk(fit(got) == fit(s_word), req, fit(got), fit(s_word));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 done without frame", rx_data, 16'h0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e, "R8 rx word", rx_data, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(2);
    chk(!miso_oe && !sio_oe, "R1 reset oe", {14'h0, miso_oe, sio_oe}, 16'h0);
    chk(!done && rx_data == 16'h0, "R8 reset rx", rx_data, 16'h0);

    // mode 0, 8 bit, msb first
    tx_data = 16'h00A5;
    sel_on();
    chk(miso_oe && miso == first_bit(16'h00A5), "R2 first bit mode0", {15'h0, miso}, 16'h1);
    chk(!sio_oe, "R9 sio released", {15'h0, sio_oe}, 16'h0);
    frame(16'h003C, 16'h00A5, 16'h0000, 99, "R5 mode0 out");
    sel_off();
    chk(!miso_oe, "R1 released after frame", {15'h0, miso_oe}, 16'h0);

    // mode 1
    cpha = 1; tx_data = 16'h005A;
    sel_on();
    chk(miso == first_bit(16'h005A), "R2 first bit mode1", {15'h0, miso}, {15'h0, first_bit(16'h005A)});
    frame(16'h0096, 16'h005A, 16'h0000, 99, "R5 mode1 out");
    sel_off();

    // mode 2, 16 bit
    cpha = 0; cpol = 1; sck = 1; wide = 1; tx_data = 16'h1234;
    wait_clk(4);
    sel_on();
    frame(16'hBEEF, 16'h1234, 16'h0000, 99, "R7 mode2 16b out");
    sel_off();

    // mode 3, 16 bit lsb first
    cpha = 1; lsb = 1; tx_data = 16'h8001;
    sel_on();
    chk(miso == 1'b1, "R6 lsb first bit", {15'h0, miso}, 16'h1);
    frame(16'hC0DE, 16'h8001, 16'h0000, 99, "R6 mode3 lsb out");
    sel_off();

    // 8 bit lsb first, zero-extended
    cpha = 0; cpol = 0; sck = 0; wide = 0; tx_data = 16'hFF80;
    wait_clk(4);
    sel_on();
    frame(16'hFF01, 16'hFF80, 16'h0000, 99, "R7 narrow lsb out");
    sel_off();
    chk(rx_data == 16'h0001, "R7 upper zero", rx_data, 16'h0001);

    // clocks while deselected
    lsb = 0; tx_data = 16'h00C3;
    for (int i = 0; i < 5; i++) begin
      sck = 1; wait_clk(HALF); sck = 0; wait_clk(HALF);
      chk(!miso_oe && !done, "R3 idle clocks", {15'h0, miso_oe}, 16'h0);
    end
    sel_on();
    frame(16'h0071, 16'h00C3, 16'h0000, 99, "R3 frame after idle clocks");
    sel_off();

    // abort mid-frame
    held = rx_data;
    tx_data = 16'h00E7;
    sel_on();
    frame(16'h00FF, 16'h00E7, 16'h00E7, 3, "R4 abort");
    sel_off();
    chk(rx_data == held, "R4 rx kept", rx_data, held);
    chk(!miso_oe, "R4 released", {15'h0, miso_oe}, 16'h0);
    sel_on();
    frame(16'h0024, 16'h00E7, 16'h0000, 99, "R4 fresh frame");
    sel_off();

    // back-to-back, both phases
    for (int p = 0; p < 2; p++) begin
      cpha = p[0]; tx_data = 16'h0011;
      wait_clk(2);
      sel_on();
      frame(16'h0055, 16'h0011, 16'h0099, 99, "R11 first of pair");
      frame(16'h00AA, 16'h0099, 16'h0000, 99, "R11 second of pair");
      sel_off();
    end

    // single wire, input direction
    cpha = 0; bidir = 1; bidir_oe = 0; tx_data = 16'h0033;
    sel_on();
    chk(!sio_oe && !miso_oe, "R10 input dir oe", {14'h0, miso_oe, sio_oe}, 16'h0);
    frame(16'h006B, 16'h0033, 16'h0000, 99, "R10 input dir");
    sel_off();

    // single wire, output direction, loopback
    bidir_oe = 1; tx_data = 16'h00D2;
    sel_on();
    chk(sio_oe && !miso_oe && sio_o == 1'b1, "R10 output dir", {14'h0, miso_oe, sio_oe}, 16'h1);
    frame(16'h0000, 16'h00D2, 16'h0000, 99, "R10 loopback out");
    sel_off();
    chk(!sio_oe, "R1 sio released", {15'h0, sio_oe}, 16'h0);

    wait_clk(10);
    chk(exp_q.size() == 0, "R8 missing done", 16'(exp_q.size()), 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule